// File: doc/BRIEF.md
# Row-Column Indirect Nonvolatile Array Port

This block gives a host indirect access to a 48-byte nonvolatile array laid out as 8 rows of 6 columns. The host selects one of three registers with a 2-bit address. The pointer register selects a location. The data register reads or writes the byte at that location. The status register reports a programming-busy flag and a sticky error flag. Every accepted data access advances the pointer. The pointer is a column counter chained to a row counter, so it walks along a row and then moves on to the next row.

Writes are not applied to the array byte by byte. Each written byte goes into a row staging buffer. Writing column 5 starts a programming cycle of fixed length, and at the end of it the whole row is replaced at once. Any column of that row that was not written since the last commit is cleared to zero. Writes need the programming-enable input. Data accesses made while the receiver is active are rejected and set the error flag. While programming is in progress, data accesses and pointer writes are ignored.

Register map for `addr_i`: 0 selects the pointer, 1 selects the data register, 2 selects status, and 3 reads zero.

Top module: `rc_eep_port`

## Requirements
- R1: After reset, the pointer reads 0, status reads 0, and every array byte reads 0.
- R2: A pointer write loads the column from wdata bits 2:0 and the row from bits 5:3, and ignores bits 7:6. A column value of 6 or 7 is loaded as column 0. A pointer read returns {2'b00, row, column}.
- R3: Each accepted data access advances the pointer by one location. Column 5 advances to column 0 of the next row, and row 7 advances to row 0.
- R4: An accepted data read returns the array byte at the pointer location.
- R5: A data write is accepted only when prog_en_i is 1, rx_active_i is 0 and no programming cycle is running. An accepted write stores the byte in the row staging buffer for its column.
- R6: A data access made while rx_active_i is 1, or a data write made while prog_en_i is 0, is rejected. A rejected access does not move the pointer and does not stage a byte, and a rejected read returns 0. A rejection sets status bit 1. Writing status with bit 1 set clears that bit.
- R7: An accepted write to column 5 starts programming. Status bit 0 then reads 1 for exactly PROG_CYCLES cycles, after which the staged row replaces the row the write was made in.
- R8: While status bit 0 is 1, data accesses and pointer writes have no effect and set no error, and a data read returns 0.
- R9: When a row is committed, every column not written since the last commit or pointer write reads 0. A pointer write discards all staged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 pointer, 1 data, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, valid while sel_i is high |
| prog_en_i | input | 1 | Programming enable from the control register |
| rx_active_i | input | 1 | Receiver active; blocks data accesses |

## Verification
The assertions assume that sel_i is a one-cycle strobe per access and that addr_i, we_i and wdata_i are stable while it is high. They also assume that prog_en_i and rx_active_i change only between accesses. The bench drives every input at the falling edge and keeps it there for a whole cycle. It changes the enable inputs only between table entries. To see whether writes during busy are ignored, the bench issues them back to back right after a column 5 write, so that they land inside the programming window.

// File: rtl/rc_eep_pkg.sv
package rc_eep_pkg;
  parameter int unsigned ROWS = 8;
  parameter int unsigned COLS = 6;
  parameter int unsigned DW   = 8;
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned COL_W = $clog2(COLS);

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef logic [COLS-1:0][DW-1:0] row_t;
endpackage

// File: rtl/rc_eep_ptr.sv
module rc_eep_ptr
  import rc_eep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DW-1:0]    load_data_i,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] ld_col;

  assign ld_col = load_data_i[COL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= load_data_i[COL_W+ROW_W-1:COL_W];
      col_q <= (32'(ld_col) >= COLS) ? '0 : ld_col;  // out-of-range column folds to 0
    end else if (adv_i) begin
      if (32'(col_q) == COLS-1) begin
        col_q <= '0;
        row_q <= (32'(row_q) == ROWS-1) ? '0 : row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(col_q) < COLS);  // R2
  AST_ROW_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && 32'(col_q) == COLS-1 |=> col_q == '0 &&
    row_q == ((32'($past(row_q)) == ROWS-1) ? '0 : $past(row_q) + ROW_W'(1)));  // R3
endmodule

// File: rtl/rc_eep_stage.sv
module rc_eep_stage
  import rc_eep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DW-1:0]    data_i,
  input  logic             clear_i,
  output row_t             buf_o,
  output logic [COLS-1:0]  valid_o
);
  row_t            buf_q;
  logic [COLS-1:0] valid_q;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[c]   <= '0;
        valid_q[c] <= 1'b0;
      end else if (clear_i) begin
        valid_q[c] <= 1'b0;
      end else if (wr_i && col_i == COL_W'(c)) begin
        buf_q[c]   <= data_i;
        valid_q[c] <= 1'b1;
      end
    end
  end

  assign buf_o   = buf_q;
  assign valid_o = valid_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> valid_q == '0);  // R9
endmodule

// File: rtl/rc_eep_array.sv
module rc_eep_array
  import rc_eep_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] start_row_i,
  input  row_t             start_data_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

  row_t [ROWS-1:0]  mem_q;
  row_t             pend_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q      <= '0;
      pend_q     <= '0;
      pend_row_q <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q     <= 1'b1;
      cnt_q      <= CNT_W'(PROG_CYCLES - 1);
      pend_q     <= start_data_i;
      pend_row_q <= start_row_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        mem_q[pend_row_q] <= pend_q;
        busy_q            <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < COLS; c++)
      if (rd_col_i == COL_W'(c)) rd_data_o = mem_q[rd_row_i][c];
  end

  assign busy_o = busy_q;

  AST_HOLD_WHILE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> $stable(mem_q));  // R7
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);  // R8
endmodule

// File: rtl/rc_eep_port.sv
module rc_eep_port
  import rc_eep_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          prog_en_i,
  input  logic          rx_active_i
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [DW-1:0]    arr_rd;
  logic             busy;
  row_t             stg_buf;
  logic [COLS-1:0]  stg_valid;
  row_t             commit_row;
  logic             err_q;

  logic data_acc, rej, ok_data, ptr_load, stage_wr, start, err_clr;

  assign data_acc = sel_i && addr_i == SEL_DATA;
  assign rej      = data_acc && !busy && (rx_active_i || (we_i && !prog_en_i));
  assign ok_data  = data_acc && !busy && !rej;
  assign ptr_load = sel_i && we_i && addr_i == SEL_PTR && !busy;
  assign stage_wr = ok_data && we_i;
  assign start    = stage_wr && 32'(col) == COLS-1;
  assign err_clr  = sel_i && we_i && addr_i == SEL_STAT && wdata_i[1];

  // unwritten columns commit as zero; the closing byte bypasses the buffer
  for (genvar c = 0; c < COLS; c++) begin : g_commit
    assign commit_row[c] = (col == COL_W'(c)) ? wdata_i :
                           (stg_valid[c] ? stg_buf[c] : '0);
  end

  rc_eep_ptr u_ptr (
    .clk_i, .rst_ni,
    .load_i      (ptr_load),
    .load_data_i (wdata_i),
    .adv_i       (ok_data),
    .row_o       (row),
    .col_o       (col)
  );

  rc_eep_stage u_stage (
    .clk_i, .rst_ni,
    .wr_i    (stage_wr),
    .col_i   (col),
    .data_i  (wdata_i),
    .clear_i (start || ptr_load),
    .buf_o   (stg_buf),
    .valid_o (stg_valid)
  );

  rc_eep_array #(.PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk_i, .rst_ni,
    .start_i      (start),
    .start_row_i  (row),
    .start_data_i (commit_row),
    .rd_row_i     (row),
    .rd_col_i     (col),
    .rd_data_o    (arr_rd),
    .busy_o       (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (rej)     err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_i)
        SEL_PTR:  rdata_o = DW'({row, col});
        SEL_DATA: rdata_o = ok_data ? arr_rd : '0;
        SEL_STAT: rdata_o = DW'({err_q, busy});
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_REJECT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej |=> err_q);  // R6
  AST_REJECT_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej |=> $stable(row) && $stable(col));  // R6
  AST_BUSY_FREEZES_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(row) && $stable(col));  // R8
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);  // R7
endmodule

// File: tb/rc_eep_port_bench.sv
module rc_eep_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, pen = 1'b0, rx = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0, rd, last;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  rc_eep_port u_rc_eep_port (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd), .prog_en_i(pen), .rx_active_i(rx)
  );

  typedef struct packed {
    logic [1:0] a; logic w; logic [7:0] d; logic rx; logic pen;
    logic chk; logic [7:0] exp; logic [3:0] req;
  } vec_t;

  // pointer walk, wrap and rejection vectors
  localparam vec_t VECS [19] = '{
    '{2'd0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 load row0 col5
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h05, 4'd2},  // R2
    '{2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 4'd4},  // R4 empty byte
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 4'd3},  // R3 carry to row1
    '{2'd0, 1'b1, 8'h3D, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 row7 col5
    '{2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 4'd4},  // R4
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 4'd3},  // R3 row wrap
    '{2'd0, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 col6 folds, top bits dropped
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h38, 4'd2},  // R2
    '{2'd1, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 write without enable
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h38, 4'd6},  // R6 no advance
    '{2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 4'd6},  // R6 error set
    '{2'd2, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 clear
    '{2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 4'd6},  // R6
    '{2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 4'd6},  // R6 read with receiver on
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h38, 4'd6},  // R6
    '{2'd1, 1'b1, 8'h44, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 write with receiver on
    '{2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h38, 4'd5},  // R5
    '{2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h02, 4'd6}   // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // called at a falling edge; holds the access for one cycle
  task automatic acc(input logic [1:0] a, input logic w, input logic [7:0] d);
    sel = 1'b1; addr = a; we = w; wd = d;
    #1 last = rd;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20; i++) begin
      acc(2'd2, 1'b0, 8'h00);
      if (!last[0]) break;
    end
  endtask

  task automatic read_row(input logic [7:0] ptr, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
                          input logic [7:0] b5, input string req);
    logic [7:0] e [6];
    e = '{b0, b1, b2, b3, b4, b5};
    acc(2'd0, 1'b1, ptr);
    for (int i = 0; i < 6; i++) begin
      acc(2'd1, 1'b0, 8'h00);
      check(req, last, e[i]);
    end
  endtask

  initial begin
    int busy_n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    acc(2'd0, 1'b0, 8'h00); check("R1 pointer", last, 8'h00);
    acc(2'd2, 1'b0, 8'h00); check("R1 status", last, 8'h00);
    acc(2'd1, 1'b0, 8'h00); check("R1 array", last, 8'h00);

    foreach (VECS[i]) begin
      rx = VECS[i].rx; pen = VECS[i].pen;
      acc(VECS[i].a, VECS[i].w, VECS[i].d);
      if (VECS[i].chk) check($sformatf("R%0d vector %0d", VECS[i].req, i), last, VECS[i].exp);
    end
    rx = 1'b0; pen = 1'b1;
    acc(2'd2, 1'b1, 8'h02);

    // full row 2, busy length
    acc(2'd0, 1'b1, 8'h10);
    for (int i = 0; i < 6; i++) acc(2'd1, 1'b1, 8'hA0 + 8'(i));
    busy_n = 0;
    for (int i = 0; i < 20; i++) begin
      acc(2'd2, 1'b0, 8'h00);
      if (!last[0]) break;
      busy_n++;
    end
    check("R7 busy cycles", 8'(busy_n), 8'd4);
    read_row(8'h10, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, "R7 R4 commit");

    // accesses inside the programming window
    acc(2'd0, 1'b1, 8'h18);
    for (int i = 0; i < 6; i++) acc(2'd1, 1'b1, 8'hB0 + 8'(i));
    acc(2'd1, 1'b1, 8'hEE);
    acc(2'd0, 1'b1, 8'h00);
    acc(2'd0, 1'b0, 8'h00); check("R8 pointer frozen", last, 8'h20);
    acc(2'd2, 1'b0, 8'h00); check("R8 busy no error", last, 8'h01);
    wait_idle();
    check("R8 idle", last, 8'h00);
    read_row(8'h18, 8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, "R8 row intact");

    // partial row clears the rest
    acc(2'd0, 1'b1, 8'h13);
    acc(2'd1, 1'b1, 8'h11); acc(2'd1, 1'b1, 8'h22); acc(2'd1, 1'b1, 8'h33);
    wait_idle();
    read_row(8'h10, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 8'h33, "R9 partial");

    // pointer write drops staged bytes
    acc(2'd0, 1'b1, 8'h20);
    acc(2'd1, 1'b1, 8'h55);
    acc(2'd0, 1'b1, 8'h25);
    acc(2'd1, 1'b1, 8'h66);
    wait_idle();
    read_row(8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h66, "R9 discard");
    acc(2'd2, 1'b0, 8'h00); check("R5 R6 no error", last, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule